// File: doc/BRIEF.md
# Synchronous Flash Command Decoder with Bank Tracker

This block sits behind the command pins of a flash device that uses an SDRAM-like synchronous interface. On every rising clock edge it decodes chip select, the three strobe pins, the bank select and the address. It keeps a record of which row is open in each of four banks and checks every command against a set of legality rules. These rules cover the mode-register load conditions, the wait after a mode load, and the precondition for a write. Each legal command becomes a one-cycle strobe, registered, together with its bank, row, column or opcode. An illegal command raises a one-cycle error flag and has no other effect.

The block does not need a precharge command. A row stays open until the next activate to the same bank, a terminate that covers the bank, power-down (clock enable low) or reset. Flash control opcodes reach downstream execution logic over a load-command path that emits a one-cycle strobe. The mode register resets to a static input that stands for the non-volatile mode value.

Top module: `flash_cmd_decoder`

## Requirements
- R1: With clock enable high, a command is registered when cs_ni is low. If cs_ni is high, or if the pins encode a NOP ({ras,cas,we}=111), no strobe and no error appear and no state changes. An operation in progress (the mode wait) keeps counting.
- R2: A mode load ({ras,cas,we}=000) with every bank closed pulses lmr_o and sets mode_o to addr_i[10:0]. If any bank is open it raises err_o and leaves mode_o unchanged.
- R3: After an accepted mode load, every non-NOP command registered in the next MRD_CYCLES-1 cycles raises err_o and has no effect. The command MRD_CYCLES cycles after the load is accepted.
- R4: An activate ({ras,cas,we}=011) pulses act_o, marks bank ba_i as open in bank_open_o and stores addr_i in that bank's slice of open_rows_o (slice b sits at bits b*ROW_W upward). bank_o and row_o report the bank and the row.
- R5: A read ({ras,cas,we}=101) to an open bank pulses rd_o with bank_o=ba_i and col_o=addr_i[7:0]. A read to a closed bank raises err_o.
- R6: A write ({ras,cas,we}=100) is legal if the addressed bank is open, or if the immediately preceding non-NOP command was an accepted load-command. Otherwise it raises err_o. A legal write pulses wr_o with bank_o and col_o, as a read does.
- R7: An active-terminate ({ras,cas,we}=010) pulses aterm_o. It closes every bank when addr_i[10]=1, and only bank ba_i otherwise.
- R8: A burst-terminate ({ras,cas,we}=110) pulses bterm_o, with bank_o and bterm_wr_o taken from the most recent accepted read (0) or write (1), and then clears that record. With no such record it raises err_o.
- R9: A load-command ({ras,cas,we}=001) pulses fcmd_valid_o with fcmd_o=addr_i[7:0].
- R10: Clock enable low on an edge closes every bank, registers no command and withdraws the write permission of R6.
- R11: After reset every strobe and err_o are low, all banks are closed and mode_o equals nv_mode_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cke_i | input | 1 | Clock enable; low is power-down |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe pin, active low |
| cas_ni | input | 1 | Column strobe pin, active low |
| we_ni | input | 1 | Write-enable pin, active low |
| ba_i | input | BA_W | Bank select |
| addr_i | input | ROW_W | Address bus |
| nv_mode_i | input | MODE_W | Reset value of the mode register |
| act_o | output | 1 | Activate strobe |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| lmr_o | output | 1 | Mode-load strobe |
| aterm_o | output | 1 | Active-terminate strobe |
| bterm_o | output | 1 | Burst-terminate strobe |
| bterm_wr_o | output | 1 | Truncated burst was a write |
| fcmd_valid_o | output | 1 | Flash control opcode strobe |
| fcmd_o | output | OP_W | Flash control opcode |
| err_o | output | 1 | Illegal command flag |
| bank_o | output | BA_W | Bank of the last strobe |
| row_o | output | ROW_W | Row of the last activate |
| col_o | output | COL_W | Column of the last read or write |
| mode_o | output | MODE_W | Current mode register |
| bank_open_o | output | BANKS | Open flag per bank |
| open_rows_o | output | BANKS*ROW_W | Open row per bank |

## Verification
The bench builds the block with MRD_CYCLES=3 and leaves the four-bank, 12-bit-row defaults in place. With a three-cycle wait, two commands in a row fall inside the wait window after a mode load, and the first command allowed after the wait can be checked against them. A behavioural model runs beside the design and is compared with it on every clock. Directed sequences cover the write-permission chain, terminate of a single bank and of all banks, burst-terminate with and without a record, and power-down. A random phase then mixes all pin codes together with chip select and clock enable.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    CMD_NOP, CMD_LMR, CMD_ACT, CMD_RD, CMD_WR, CMD_ATERM, CMD_BTERM, CMD_LCR
  } cmd_e;

  function automatic cmd_e pins_to_cmd(input logic ras_n, input logic cas_n, input logic we_n);
    unique case ({ras_n, cas_n, we_n})
      3'b000:  return CMD_LMR;
      3'b011:  return CMD_ACT;
      3'b101:  return CMD_RD;
      3'b100:  return CMD_WR;
      3'b010:  return CMD_ATERM;
      3'b110:  return CMD_BTERM;
      3'b001:  return CMD_LCR;
      default: return CMD_NOP;
    endcase
  endfunction
endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
(
  input  logic cke_i,
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output cmd_e cmd_o,
  output logic exec_o
);
  assign cmd_o  = pins_to_cmd(ras_ni, cas_ni, we_ni);
  // executable: registered and not a NOP
  assign exec_o = cke_i && !cs_ni && (cmd_o != CMD_NOP);
endmodule

// File: rtl/flash_mrd_timer.sv
module flash_mrd_timer #(
  parameter int MRD_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);
  localparam int CW = (MRD_CYCLES < 2) ? 1 : $clog2(MRD_CYCLES + 1);
  localparam logic [CW-1:0] RELOAD = CW'(MRD_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= RELOAD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  generate
    if (MRD_CYCLES > 1) begin : g_chk
      p_wait_after_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> busy_o);
    end
  endgenerate
  p_no_load_while_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !load_i);
endmodule

// File: rtl/flash_bank_table.sv
module flash_bank_table #(
  parameter int BANKS = 4,
  parameter int ROW_W = 12,
  localparam int BA_W = (BANKS < 2) ? 1 : $clog2(BANKS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   act_i,
  input  logic [BA_W-1:0]        act_bank_i,
  input  logic [ROW_W-1:0]       act_row_i,
  input  logic [BANKS-1:0]       close_i,
  output logic [BANKS-1:0]       open_o,
  output logic [BANKS*ROW_W-1:0] rows_o
);
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic             open_q;
    logic [ROW_W-1:0] row_q;
    logic             hit;
    assign hit = act_i && (act_bank_i == BA_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_q <= 1'b0;
        row_q  <= '0;
      end else if (close_i[b]) begin
        open_q <= 1'b0;
      end else if (hit) begin
        open_q <= 1'b1;
        row_q  <= act_row_i;
      end
    end

    assign open_o[b] = open_q;
    assign rows_o[b*ROW_W +: ROW_W] = row_q;
  end

  p_act_opens_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && close_i == '0) |=> open_o[$past(act_bank_i)]);
  p_close_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (close_i == {BANKS{1'b1}}) |=> (open_o == '0));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int BANKS      = 4,
  parameter int ROW_W      = 12,
  parameter int COL_W      = 8,
  parameter int MODE_W     = 11,
  parameter int OP_W       = 8,
  parameter int MRD_CYCLES = 2,
  parameter int ALL_BIT    = 10,
  localparam int BA_W = (BANKS < 2) ? 1 : $clog2(BANKS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cke_i,
  input  logic                   cs_ni,
  input  logic                   ras_ni,
  input  logic                   cas_ni,
  input  logic                   we_ni,
  input  logic [BA_W-1:0]        ba_i,
  input  logic [ROW_W-1:0]       addr_i,
  input  logic [MODE_W-1:0]      nv_mode_i,
  output logic                   act_o,
  output logic                   rd_o,
  output logic                   wr_o,
  output logic                   lmr_o,
  output logic                   aterm_o,
  output logic                   bterm_o,
  output logic                   bterm_wr_o,
  output logic                   fcmd_valid_o,
  output logic [OP_W-1:0]        fcmd_o,
  output logic                   err_o,
  output logic [BA_W-1:0]        bank_o,
  output logic [ROW_W-1:0]       row_o,
  output logic [COL_W-1:0]       col_o,
  output logic [MODE_W-1:0]      mode_o,
  output logic [BANKS-1:0]       bank_open_o,
  output logic [BANKS*ROW_W-1:0] open_rows_o
);
  cmd_e cmd;
  logic exec, busy, go, sel_open, any_open;
  logic lmr_ok, act_ok, rd_ok, wr_ok, at_ok, bt_ok, lcr_ok, bad;
  logic [BANKS-1:0] close_mask;
  logic permit_q, rec_v_q, rec_wr_q;
  logic [BA_W-1:0] rec_bank_q;
  logic [MODE_W-1:0] mode_q;

  flash_cmd_decode u_dec (
    .cke_i, .cs_ni, .ras_ni, .cas_ni, .we_ni,
    .cmd_o (cmd), .exec_o (exec)
  );

  flash_mrd_timer #(.MRD_CYCLES(MRD_CYCLES)) u_mrd (
    .clk_i, .rst_ni, .load_i (lmr_ok), .busy_o (busy)
  );

  flash_bank_table #(.BANKS(BANKS), .ROW_W(ROW_W)) u_banks (
    .clk_i, .rst_ni,
    .act_i      (act_ok),
    .act_bank_i (ba_i),
    .act_row_i  (addr_i),
    .close_i    (close_mask),
    .open_o     (bank_open_o),
    .rows_o     (open_rows_o)
  );

  always_comb begin
    go       = exec && !busy;
    sel_open = bank_open_o[ba_i];
    any_open = |bank_open_o;
    lmr_ok   = go && (cmd == CMD_LMR) && !any_open;
    act_ok   = go && (cmd == CMD_ACT);
    rd_ok    = go && (cmd == CMD_RD) && sel_open;
    wr_ok    = go && (cmd == CMD_WR) && (sel_open || permit_q);
    at_ok    = go && (cmd == CMD_ATERM);
    bt_ok    = go && (cmd == CMD_BTERM) && rec_v_q;
    lcr_ok   = go && (cmd == CMD_LCR);
    bad      = exec && !(lmr_ok || act_ok || rd_ok || wr_ok || at_ok || bt_ok || lcr_ok);
    close_mask = '0;
    if (!cke_i) close_mask = '1;
    else if (at_ok) begin
      if (addr_i[ALL_BIT]) close_mask = '1;
      else                 close_mask[ba_i] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {act_o, rd_o, wr_o, lmr_o, aterm_o, bterm_o, fcmd_valid_o, err_o} <= '0;
      bterm_wr_o <= 1'b0;
      fcmd_o     <= '0;
      bank_o     <= '0;
      row_o      <= '0;
      col_o      <= '0;
      mode_q     <= nv_mode_i;
      permit_q   <= 1'b0;
      rec_v_q    <= 1'b0;
      rec_wr_q   <= 1'b0;
      rec_bank_q <= '0;
    end else begin
      act_o        <= act_ok;
      rd_o         <= rd_ok;
      wr_o         <= wr_ok;
      lmr_o        <= lmr_ok;
      aterm_o      <= at_ok;
      bterm_o      <= bt_ok;
      fcmd_valid_o <= lcr_ok;
      err_o        <= bad;
      if (lmr_ok) mode_q <= addr_i[MODE_W-1:0];
      if (lcr_ok) fcmd_o <= addr_i[OP_W-1:0];
      if (act_ok) row_o  <= addr_i;
      if (rd_ok || wr_ok) col_o <= addr_i[COL_W-1:0];
      if (act_ok || rd_ok || wr_ok || at_ok) bank_o <= ba_i;
      if (bt_ok) begin
        bank_o     <= rec_bank_q;
        bterm_wr_o <= rec_wr_q;
        rec_v_q    <= 1'b0;
      end else if (rd_ok || wr_ok) begin
        rec_v_q    <= 1'b1;
        rec_wr_q   <= wr_ok;
        rec_bank_q <= ba_i;
      end
      // write permission lives for exactly one following executable command
      if (!cke_i)    permit_q <= 1'b0;
      else if (exec) permit_q <= lcr_ok;
    end
  end

  assign mode_o = mode_q;

  p_one_strobe_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({act_o, rd_o, wr_o, lmr_o, aterm_o, bterm_o, fcmd_valid_o, err_o}));
  p_deselect_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !(act_o || rd_o || wr_o || lmr_o || aterm_o || bterm_o || fcmd_valid_o || err_o));
  p_mode_load_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lmr_o |-> (bank_open_o == '0));
  p_mode_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lmr_o |-> $stable(mode_o));
  p_read_open_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |-> bank_open_o[bank_o]);
  p_powerdown_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_i |=> (bank_open_o == '0) && !err_o && !act_o);
endmodule

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;
  localparam int BANKS = 4, ROW_W = 12, COL_W = 8, MODE_W = 11, OP_W = 8, BA_W = 2;
  localparam int MRD = 3;
  localparam logic [MODE_W-1:0] NV_MODE = 11'h1B3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [BA_W-1:0] ba = '0;
  logic [ROW_W-1:0] addr = '0;
  logic act, rd, wr, lmr, aterm, bterm, bterm_wr, fval, err;
  logic [OP_W-1:0] fcmd;
  logic [BA_W-1:0] bank;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  logic [MODE_W-1:0] mode;
  logic [BANKS-1:0] bopen;
  logic [BANKS*ROW_W-1:0] orows;

  always #2.5 clk = ~clk;

  flash_cmd_decoder #(.MRD_CYCLES(MRD)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n),
    .cas_ni(cas_n), .we_ni(we_n), .ba_i(ba), .addr_i(addr), .nv_mode_i(NV_MODE),
    .act_o(act), .rd_o(rd), .wr_o(wr), .lmr_o(lmr), .aterm_o(aterm), .bterm_o(bterm),
    .bterm_wr_o(bterm_wr), .fcmd_valid_o(fval), .fcmd_o(fcmd), .err_o(err),
    .bank_o(bank), .row_o(row), .col_o(col), .mode_o(mode),
    .bank_open_o(bopen), .open_rows_o(orows)
  );

  int checks = 0, fails = 0;
  logic running = 1'b0;

  // reference model state
  bit m_open[BANKS];
  logic [ROW_W-1:0] m_row[BANKS];
  int m_wait, m_permit, m_rec_v, m_rec_wr, m_rec_bank;
  logic [7:0] e_strobe; // act rd wr lmr aterm bterm fval err
  logic e_bwr;
  logic [OP_W-1:0] e_fcmd;
  logic [BA_W-1:0] e_bank;
  logic [ROW_W-1:0] e_row;
  logic [COL_W-1:0] e_col;
  logic [MODE_W-1:0] e_mode;
  string e_tag;

  task automatic model_reset();
    for (int b = 0; b < BANKS; b++) begin m_open[b] = 0; m_row[b] = '0; end
    m_wait = 0; m_permit = 0; m_rec_v = 0; m_rec_wr = 0; m_rec_bank = 0;
    e_strobe = '0; e_bwr = 0; e_fcmd = '0; e_bank = '0; e_row = '0; e_col = '0;
    e_mode = NV_MODE; e_tag = "R11";
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      int any, busy, ok, code;
      busy = (m_wait > 0);
      if (m_wait > 0) m_wait--;
      e_strobe = '0;
      any = 0;
      for (int b = 0; b < BANKS; b++) any |= m_open[b];
      code = {ras_n, cas_n, we_n};
      if (!cke) begin
        for (int b = 0; b < BANKS; b++) m_open[b] = 0;
        m_permit = 0; e_tag = "R10";
      end else if (cs_n || code == 7) begin
        e_tag = "R1";
      end else if (busy) begin
        e_strobe[0] = 1; m_permit = 0; e_tag = "R3";
      end else begin
        ok = 0;
        case (code)
          0: begin e_tag = "R2";
            if (!any) begin ok = 1; e_strobe[4] = 1; e_mode = addr[MODE_W-1:0]; m_wait = MRD - 1; end end
          3: begin e_tag = "R4"; ok = 1; e_strobe[7] = 1; m_open[ba] = 1; m_row[ba] = addr;
            e_bank = ba; e_row = addr; end
          5: begin e_tag = "R5";
            if (m_open[ba]) begin ok = 1; e_strobe[6] = 1; e_bank = ba; e_col = addr[7:0];
              m_rec_v = 1; m_rec_wr = 0; m_rec_bank = ba; end end
          4: begin e_tag = "R6";
            if (m_open[ba] || m_permit != 0) begin ok = 1; e_strobe[5] = 1; e_bank = ba;
              e_col = addr[7:0]; m_rec_v = 1; m_rec_wr = 1; m_rec_bank = ba; end end
          2: begin e_tag = "R7"; ok = 1; e_strobe[3] = 1; e_bank = ba;
            if (addr[10]) for (int b = 0; b < BANKS; b++) m_open[b] = 0;
            else m_open[ba] = 0; end
          6: begin e_tag = "R8";
            if (m_rec_v != 0) begin ok = 1; e_strobe[2] = 1; e_bank = m_rec_bank[BA_W-1:0];
              e_bwr = m_rec_wr[0]; m_rec_v = 0; end end
          default: begin e_tag = "R9"; ok = 1; e_strobe[1] = 1; e_fcmd = addr[7:0]; end
        endcase
        if (!ok) e_strobe[0] = 1;
        m_permit = (code == 1) ? 1 : 0;
      end
    end
  end

  task automatic chk(string tag, string what, logic [63:0] act_v, logic [63:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act_v, exp_v, $time);
    end
  endtask

  always @(negedge clk) if (running) begin
    logic [BANKS-1:0] eo;
    logic [BANKS*ROW_W-1:0] er;
    for (int b = 0; b < BANKS; b++) begin eo[b] = m_open[b]; er[b*ROW_W +: ROW_W] = m_row[b]; end
    chk(e_tag, "strobes", {act, rd, wr, lmr, aterm, bterm, fval, err}, e_strobe);
    chk("R2", "mode", mode, e_mode);
    chk("R4", "bank_open", bopen, eo);
    chk("R4", "open_rows", orows & {BANKS{{ROW_W{1'b1}}}}, er);
    chk("R4", "bank/row", {bank, row}, {e_bank, e_row});
    chk("R5", "col", col, e_col);
    chk("R8", "bterm_wr", bterm_wr, e_bwr);
    chk("R9", "fcmd", fcmd, e_fcmd);
  end

  task automatic drive(bit c, bit s, logic [2:0] pins, int b, int a);
    @(negedge clk);
    cke = c; cs_n = s; {ras_n, cas_n, we_n} = pins; ba = BA_W'(b); addr = ROW_W'(a);
  endtask
  task automatic cmd(logic [2:0] pins, int b, int a); drive(1, 0, pins, b, a); endtask
  task automatic nop(); drive(1, 0, 3'b111, 0, 0); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    running = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11", "reset mode", mode, NV_MODE);
    chk("R11", "reset banks", bopen, '0);
    cmd(3'b111, 0, 0);                  // R1 NOP
    drive(1, 1, 3'b000, 0, 12'h0AA);    // R1 deselected mode load
    cmd(3'b000, 0, 12'h2A5);            // R2 accepted
    cmd(3'b011, 1, 12'h123);            // R3 blocked
    cmd(3'b001, 0, 12'h033);            // R3 blocked
    cmd(3'b011, 1, 12'h123);            // R4 accepted after wait
    cmd(3'b101, 1, 12'h045);            // R5 read open bank
    cmd(3'b101, 2, 12'h011);            // R5 read closed -> err
    cmd(3'b100, 2, 12'h012);            // R6 no permit -> err
    cmd(3'b001, 0, 12'h040);            // R9 load-command
    nop();                              // NOP keeps permission
    cmd(3'b100, 2, 12'h077);            // R6 permitted write
    cmd(3'b100, 2, 12'h078);            // R6 permission used -> err
    cmd(3'b000, 0, 12'h111);            // R2 bank open -> err
    cmd(3'b110, 0, 0);                  // R8 truncates write bank 2
    cmd(3'b110, 0, 0);                  // R8 no record -> err
    cmd(3'b101, 1, 12'h0F0);            // R5
    cmd(3'b110, 3, 0);                  // R8 truncates read bank 1
    cmd(3'b010, 1, 12'h000);            // R7 single bank
    cmd(3'b011, 0, 12'hABC);
    cmd(3'b011, 3, 12'hDEF);
    cmd(3'b010, 0, 12'h400);            // R7 all banks
    cmd(3'b011, 0, 12'h555);
    cmd(3'b001, 0, 12'h0C3);
    drive(0, 0, 3'b101, 0, 0);          // R10 power-down
    cmd(3'b100, 1, 12'h001);            // R10 permission withdrawn -> err
    @(negedge clk);
    chk("R10", "banks closed", bopen, '0);
    cmd(3'b000, 0, 12'h7FF);            // R2 legal again
    for (int i = 0; i < 3000; i++)
      drive(($urandom % 16) != 0, ($urandom % 6) == 0, 3'($urandom), $urandom, $urandom);
    nop(); nop();
    running = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule